// File: doc/BRIEF.md
# Single-Channel DMA Control Sequencer

This block is the control and status core of one DMA channel. Software programs a working memory address, a transfer count and a function code, plus a base copy of each, then starts the channel through a control word. Once running, the channel latches pulses from an external requester. For each latched request it runs one operand transfer on a request/acknowledge handshake, and the bus can answer that handshake with an exception. After every good transfer the address steps by the operand size and the count drops by one. The channel ends when the count runs out, unless a continuation is pending. In that case it reloads the working registers from the base copies and starts the next block on its own.

The block is a four-state machine. In `ST_IDLE` nothing runs; a valid start goes to `ST_ARMED`. `ST_ARMED` goes to `ST_PAUSED` while halt is set and to `ST_XFER` when a request is pending. `ST_PAUSED` goes back to `ST_ARMED` once halt clears. `ST_XFER` holds the bus request until the transfer ends:
- an exception goes to `ST_IDLE`;
- a good transfer that is not the last goes to `ST_ARMED`;
- the last transfer with continuation goes to `ST_ARMED` after a reload;
- the last transfer without continuation goes to `ST_IDLE`.

From any active state, a software abort goes to `ST_IDLE`. Status bits, an error code and a level interrupt report how the channel ended.

Register select codes: 0 control, 1 status, 2 error code, 3 address, 4 count, 5 function code, 6 base address, 7 base count, 8 base function code. Any other select reads zero.

Top module: `dma_chan_seq`

## Requirements
- R1: After reset the channel is idle, every register and status bit reads 0, and `bus_req` and `irq` are 0.
- R2: A write to select 0 with bit0 (go) set, bit2 (halt) clear and bit3 (abort) clear starts an idle channel, so status bit0 (active) reads 1 afterwards. A go write with halt set leaves the channel idle. The control word also holds continue (bit1), interrupt enable (bit4) and size code (bits 6:5); go and abort always read back as 0.
- R3: Each latched request produces one bus cycle. `bus_req` stays high until `bus_ack` or `bus_err`. On an acknowledge the address steps by the size code's byte count: code 0 gives 1, code 1 gives 2, and codes 2 and 3 give 4.
- R4: After each acknowledge the count drops by 1. When it reaches 0 with continue clear, the channel goes idle, status bit2 (complete) is set, status bit3 (error) stays clear and the error code (select 2) is 0.
- R5: When the count reaches 0 with continue set, the base address, base count and base function code are copied into the working registers. Status bit1 (block done) is set, continue is cleared, and the channel stays active for the next block.
- R6: Writing control bit3 while the channel is active ends it at once. `bus_req` drops, complete and error are set, and the error code is 3. Abort while idle has no effect.
- R7: `bus_err` during a bus cycle ends the channel with complete and error set and error code 1. Address and count are not stepped.
- R8: While halt is set, the channel issues no bus cycle. A request latched during the halt is serviced after halt is cleared.
- R9: A start with count 0, or a continuation whose base count is 0, sets complete and error with error code 2 and leaves the channel idle.
- R10: `irq` is high exactly when interrupt enable is set and at least one of block done, complete, or status bit4 (peripheral transition, set by a `periph_fall` pulse) is set.
- R11: Writing 1 to status bits 1 to 4 clears them. A set in the same cycle wins over the clear.
- R12: Writes to the working address, count and function code are ignored while the channel is active. The base registers can be written at any time.
- R13: Request pulses seen while the channel is idle are dropped and do not cause a bus cycle after a later start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 4 | Register select for writes |
| wr_data | input | DATA_W | Write data |
| rd_sel | input | 4 | Register select for reads |
| rd_data | output | DATA_W | Read data (combinational) |
| xfer_req | input | 1 | Transfer request pulse from the peripheral |
| periph_fall | input | 1 | Peripheral control transition pulse |
| bus_req | output | 1 | Bus cycle request for one operand |
| bus_ack | input | 1 | Bus cycle completed normally |
| bus_err | input | 1 | Bus cycle ended with an exception |
| bus_addr | output | ADDR_W | Operand address |
| bus_fc | output | FC_W | Function code for the bus cycle |
| bus_size | output | 2 | Operand size code |
| irq | output | 1 | Level interrupt request |

## Verification
The bench uses the default widths: a 32-bit address and data path, a 16-bit count and a 3-bit function code. Because the requester and the bus answers are driven directly, blocks of one to five operands are enough to reach the last-operand boundary, the base reload and a zero base count in a few dozen cycles. With the full 32-bit address, every size step can be checked exactly against the reference model. Those short blocks also leave room to exercise abort in the middle of a bus cycle, a halt that holds back a latched request, and a status clear that lands in the same cycle as a set.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ARMED  = 2'd1,
        ST_PAUSED = 2'd2,
        ST_XFER   = 2'd3
    } chan_state_e;

    typedef enum logic [1:0] {
        EC_NONE  = 2'd0,
        EC_BUS   = 2'd1,
        EC_CFG   = 2'd2,
        EC_ABORT = 2'd3
    } err_code_e;

    localparam int SEL_W = 4;
    localparam logic [SEL_W-1:0] SEL_CTRL  = 4'd0;
    localparam logic [SEL_W-1:0] SEL_STAT  = 4'd1;
    localparam logic [SEL_W-1:0] SEL_ERR   = 4'd2;
    localparam logic [SEL_W-1:0] SEL_ADDR  = 4'd3;
    localparam logic [SEL_W-1:0] SEL_CNT   = 4'd4;
    localparam logic [SEL_W-1:0] SEL_FC    = 4'd5;
    localparam logic [SEL_W-1:0] SEL_BADDR = 4'd6;
    localparam logic [SEL_W-1:0] SEL_BCNT  = 4'd7;
    localparam logic [SEL_W-1:0] SEL_BFC   = 4'd8;

    // control word bit positions
    localparam int CB_GO    = 0;
    localparam int CB_CONT  = 1;
    localparam int CB_HALT  = 2;
    localparam int CB_ABORT = 3;
    localparam int CB_IEN   = 4;
    localparam int CB_SIZE  = 5;

    function automatic logic [2:0] size_bytes(input logic [1:0] code);
        case (code)
            2'd0:    size_bytes = 3'd1;
            2'd1:    size_bytes = 3'd2;
            default: size_bytes = 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/dma_seq_ctrl.sv
module dma_seq_ctrl
    import dma_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctrl_wr,
    input  logic [6:0] ctrl_bits,
    input  logic       reload,
    input  logic       idle,
    input  logic       take,
    input  logic       req,
    output logic       cont_q,
    output logic       halt_q,
    output logic       ien_q,
    output logic [1:0] size_q,
    output logic       pend_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cont_q <= 1'b0;
            halt_q <= 1'b0;
            ien_q  <= 1'b0;
            size_q <= 2'd0;
        end else begin
            if (ctrl_wr) begin
                cont_q <= ctrl_bits[CB_CONT];
                halt_q <= ctrl_bits[CB_HALT];
                ien_q  <= ctrl_bits[CB_IEN];
                size_q <= ctrl_bits[CB_SIZE+1:CB_SIZE];
            end
            if (reload) begin
                cont_q <= 1'b0;
            end
        end
    end

    // request latch: dropped while idle, consumed when a bus cycle begins
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (idle) begin
            pend_q <= 1'b0;
        end else begin
            pend_q <= req | (pend_q & ~take);
        end
    end

endmodule

// File: rtl/dma_seq_regs.sv
module dma_seq_regs
    import dma_seq_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int FC_W   = 3,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              idle,
    input  logic              step,
    input  logic              reload,
    input  logic [1:0]        size_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [CNT_W-1:0]  cnt_q,
    output logic [FC_W-1:0]   fc_q,
    output logic [ADDR_W-1:0] baddr_q,
    output logic [CNT_W-1:0]  bcnt_q,
    output logic [FC_W-1:0]   bfc_q
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [ADDR_W-1:0] addr_inc;
    assign addr_inc = ADDR_W'(size_bytes(size_q));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            cnt_q  <= '0;
            fc_q   <= '0;
        end else if (reload) begin
            addr_q <= baddr_q;
            cnt_q  <= bcnt_q;
            fc_q   <= bfc_q;
        end else if (step) begin
            addr_q <= addr_q + addr_inc;
            cnt_q  <= cnt_q - CNT_ONE;
        end else if (wr_en && idle) begin
            case (wr_sel)
                SEL_ADDR: addr_q <= wr_data[ADDR_W-1:0];
                SEL_CNT:  cnt_q  <= wr_data[CNT_W-1:0];
                SEL_FC:   fc_q   <= wr_data[FC_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            baddr_q <= '0;
            bcnt_q  <= '0;
            bfc_q   <= '0;
        end else if (wr_en) begin
            case (wr_sel)
                SEL_BADDR: baddr_q <= wr_data[ADDR_W-1:0];
                SEL_BCNT:  bcnt_q  <= wr_data[CNT_W-1:0];
                SEL_BFC:   bfc_q   <= wr_data[FC_W-1:0];
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/dma_seq_fsm.sv
module dma_seq_fsm
    import dma_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctrl_wr,
    input  logic        wr_go,
    input  logic        wr_halt,
    input  logic        wr_abort,
    input  logic        halt_q,
    input  logic        cont_q,
    input  logic        pend_q,
    input  logic        cnt_zero,
    input  logic        cnt_last,
    input  logic        bcnt_zero,
    input  logic        bus_ack,
    input  logic        bus_err,
    output chan_state_e state_q,
    output logic        take,
    output logic        step,
    output logic        reload,
    output logic        launch,
    output logic        finish,
    output err_code_e   fin_code
);

    chan_state_e state_d;
    logic        abort_cmd;
    logic        start_cmd;

    assign abort_cmd = ctrl_wr & wr_abort;
    assign start_cmd = ctrl_wr & wr_go & ~wr_halt & ~wr_abort;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d  = state_q;
        take     = 1'b0;
        step     = 1'b0;
        reload   = 1'b0;
        launch   = 1'b0;
        finish   = 1'b0;
        fin_code = EC_NONE;
        if (abort_cmd && state_q != ST_IDLE) begin
            finish   = 1'b1;
            fin_code = EC_ABORT;
            state_d  = ST_IDLE;
        end else if (start_cmd && state_q == ST_IDLE) begin
            if (cnt_zero) begin
                finish   = 1'b1;
                fin_code = EC_CFG;
            end else begin
                launch  = 1'b1;
                state_d = ST_ARMED;
            end
        end else begin
            unique case (state_q)
                ST_IDLE: ;
                ST_ARMED: begin
                    if (halt_q) begin
                        state_d = ST_PAUSED;
                    end else if (pend_q) begin
                        take    = 1'b1;
                        state_d = ST_XFER;
                    end
                end
                ST_PAUSED: begin
                    if (!halt_q) begin
                        state_d = ST_ARMED;
                    end
                end
                ST_XFER: begin
                    if (bus_err) begin
                        finish   = 1'b1;
                        fin_code = EC_BUS;
                        state_d  = ST_IDLE;
                    end else if (bus_ack) begin
                        if (!cnt_last) begin
                            step    = 1'b1;
                            state_d = ST_ARMED;
                        end else if (!cont_q) begin
                            step    = 1'b1;
                            finish  = 1'b1;
                            state_d = ST_IDLE;
                        end else if (bcnt_zero) begin
                            step     = 1'b1;
                            finish   = 1'b1;
                            fin_code = EC_CFG;
                            state_d  = ST_IDLE;
                        end else begin
                            reload  = 1'b1;
                            state_d = ST_ARMED;
                        end
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/dma_seq_status.sv
module dma_seq_status
    import dma_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stat_wr,
    input  logic [4:1] clr_bits,
    input  logic       finish,
    input  err_code_e  fin_code,
    input  logic       launch,
    input  logic       reload,
    input  logic       pcl_evt,
    input  logic       ien_q,
    output logic       blk_q,
    output logic       opd_q,
    output logic       err_q,
    output logic       pct_q,
    output err_code_e  code_q,
    output logic       irq
);

    logic [4:1] clr;
    assign clr = stat_wr ? clr_bits : 4'b0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            blk_q  <= 1'b0;
            opd_q  <= 1'b0;
            err_q  <= 1'b0;
            pct_q  <= 1'b0;
            code_q <= EC_NONE;
        end else begin
            blk_q <= (blk_q & ~clr[1]) | reload;
            opd_q <= (opd_q & ~clr[2]) | finish;
            err_q <= (err_q & ~clr[3]) | (finish & (fin_code != EC_NONE));
            pct_q <= (pct_q & ~clr[4]) | pcl_evt;
            if (finish) begin
                code_q <= fin_code;
            end else if (launch) begin
                code_q <= EC_NONE;
            end
        end
    end

    assign irq = ien_q & (blk_q | opd_q | pct_q);

endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
    import dma_seq_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int FC_W   = 3,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [3:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [3:0]        rd_sel,
    output logic [DATA_W-1:0] rd_data,
    input  logic              xfer_req,
    input  logic              periph_fall,
    output logic              bus_req,
    input  logic              bus_ack,
    input  logic              bus_err,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [FC_W-1:0]   bus_fc,
    output logic [1:0]        bus_size,
    output logic              irq
);

    chan_state_e       state_q;
    err_code_e         fin_code;
    err_code_e         err_code;
    logic              take, step, reload, launch, finish;
    logic              cont_q, halt_q, ien_q, pend_q;
    logic [1:0]        size_q;
    logic [ADDR_W-1:0] addr_q, baddr_q;
    logic [CNT_W-1:0]  cnt_q, bcnt_q;
    logic [FC_W-1:0]   fc_q, bfc_q;
    logic              stat_blk, stat_opd, stat_err, stat_pct;
    logic              active, idle, ctrl_wr, stat_wr;

    assign idle    = (state_q == ST_IDLE);
    assign active  = ~idle;
    assign ctrl_wr = wr_en && (wr_sel == SEL_CTRL);
    assign stat_wr = wr_en && (wr_sel == SEL_STAT);

    dma_seq_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_wr   (ctrl_wr),
        .ctrl_bits (wr_data[6:0]),
        .reload    (reload),
        .idle      (idle),
        .take      (take),
        .req       (xfer_req),
        .cont_q    (cont_q),
        .halt_q    (halt_q),
        .ien_q     (ien_q),
        .size_q    (size_q),
        .pend_q    (pend_q)
    );

    dma_seq_regs #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W),
        .FC_W   (FC_W),
        .DATA_W (DATA_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .idle    (idle),
        .step    (step),
        .reload  (reload),
        .size_q  (size_q),
        .addr_q  (addr_q),
        .cnt_q   (cnt_q),
        .fc_q    (fc_q),
        .baddr_q (baddr_q),
        .bcnt_q  (bcnt_q),
        .bfc_q   (bfc_q)
    );

    dma_seq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_wr   (ctrl_wr),
        .wr_go     (wr_data[CB_GO]),
        .wr_halt   (wr_data[CB_HALT]),
        .wr_abort  (wr_data[CB_ABORT]),
        .halt_q    (halt_q),
        .cont_q    (cont_q),
        .pend_q    (pend_q),
        .cnt_zero  (cnt_q == '0),
        .cnt_last  (cnt_q == CNT_W'(1)),
        .bcnt_zero (bcnt_q == '0),
        .bus_ack   (bus_ack),
        .bus_err   (bus_err),
        .state_q   (state_q),
        .take      (take),
        .step      (step),
        .reload    (reload),
        .launch    (launch),
        .finish    (finish),
        .fin_code  (fin_code)
    );

    dma_seq_status u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .stat_wr  (stat_wr),
        .clr_bits (wr_data[4:1]),
        .finish   (finish),
        .fin_code (fin_code),
        .launch   (launch),
        .reload   (reload),
        .pcl_evt  (periph_fall),
        .ien_q    (ien_q),
        .blk_q    (stat_blk),
        .opd_q    (stat_opd),
        .err_q    (stat_err),
        .pct_q    (stat_pct),
        .code_q   (err_code),
        .irq      (irq)
    );

    assign bus_req  = (state_q == ST_XFER);
    assign bus_addr = addr_q;
    assign bus_fc   = fc_q;
    assign bus_size = size_q;

    always_comb begin
        rd_data = '0;
        case (rd_sel)
            SEL_CTRL:  rd_data = DATA_W'({size_q, ien_q, 1'b0, halt_q, cont_q, 1'b0});
            SEL_STAT:  rd_data = DATA_W'({stat_pct, stat_err, stat_opd, stat_blk, active});
            SEL_ERR:   rd_data = DATA_W'(err_code);
            SEL_ADDR:  rd_data = DATA_W'(addr_q);
            SEL_CNT:   rd_data = DATA_W'(cnt_q);
            SEL_FC:    rd_data = DATA_W'(fc_q);
            SEL_BADDR: rd_data = DATA_W'(baddr_q);
            SEL_BCNT:  rd_data = DATA_W'(bcnt_q);
            SEL_BFC:   rd_data = DATA_W'(bfc_q);
            default:   rd_data = '0;
        endcase
    end

endmodule

// File: rtl/dma_seq_chk.sv
module dma_seq_chk
    import dma_seq_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [3:0]        wr_sel,
    input logic [3:0]        ctl_bits,
    input logic              bus_req,
    input logic              bus_ack,
    input logic              bus_err,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              active,
    input logic              err_st,
    input err_code_e         err_code,
    input logic [CNT_W-1:0]  cnt_q,
    input logic [1:0]        size_q,
    input logic              halt_q,
    input logic              ien_q,
    input logic              irq
);

    logic abort_wr;
    logic halted_go;
    assign abort_wr  = wr_en && (wr_sel == SEL_CTRL) && ctl_bits[CB_ABORT];
    assign halted_go = wr_en && (wr_sel == SEL_CTRL) && ctl_bits[CB_GO] && ctl_bits[CB_HALT];

    assert_bus_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack && !bus_err && !abort_wr |=> bus_req);

    assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_ack && !bus_err && !abort_wr && cnt_q != CNT_W'(1)
        |=> bus_addr == $past(bus_addr) + ADDR_W'(size_bytes($past(size_q))));

    assert_halted_go_R2: assert property (@(posedge clk) disable iff (!rst_n)
        halted_go && !active |=> !active);

    assert_abort_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        abort_wr && active |=> !active && !bus_req && err_code == EC_ABORT);

    assert_bus_exc_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_err && !abort_wr |=> !active && err_st && err_code == EC_BUS);

    assert_halt_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        halt_q && active && !bus_req |=> !bus_req);

    assert_end_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(active) && ien_q |-> irq);

endmodule

bind dma_chan_seq dma_seq_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .ctl_bits (wr_data[3:0]),
    .bus_req  (bus_req),
    .bus_ack  (bus_ack),
    .bus_err  (bus_err),
    .bus_addr (bus_addr),
    .active   (active),
    .err_st   (stat_err),
    .err_code (err_code),
    .cnt_q    (cnt_q),
    .size_q   (size_q),
    .halt_q   (halt_q),
    .ien_q    (ien_q),
    .irq      (irq)
);

// File: tb/sim_dma_chan_seq.sv
`timescale 1ns/1ps
module sim_dma_chan_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_sel = 4'd0;
    logic [31:0] wr_data = 32'd0;
    logic [3:0]  rd_sel = 4'd1;
    logic [31:0] rd_data;
    logic        xfer_req = 1'b0;
    logic        periph_fall = 1'b0;
    logic        bus_req;
    logic        bus_ack = 1'b0;
    logic        bus_err = 1'b0;
    logic [31:0] bus_addr;
    logic [2:0]  bus_fc;
    logic [1:0]  bus_size;
    logic        irq;

    int n_run = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dma_chan_seq u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .xfer_req(xfer_req), .periph_fall(periph_fall),
        .bus_req(bus_req), .bus_ack(bus_ack), .bus_err(bus_err), .bus_addr(bus_addr),
        .bus_fc(bus_fc), .bus_size(bus_size), .irq(irq)
    );

    // ---------------- behavioural reference model ----------------
    int          m_st;       // 0 idle, 1 waiting, 2 paused, 3 on bus
    logic [31:0] m_addr, m_baddr;
    logic [15:0] m_cnt, m_bcnt;
    logic [2:0]  m_fc, m_bfc;
    logic        m_cont, m_halt, m_ien, m_pend;
    logic [1:0]  m_size;
    logic        m_blk, m_opd, m_err, m_pct;
    int          m_code;

    function automatic int nbytes(input logic [1:0] s);
        if (s == 2'd0) return 1;
        if (s == 2'd1) return 2;
        return 4;
    endfunction

    function automatic logic [31:0] m_read(input logic [3:0] s);
        case (s)
            4'd0: return {25'd0, m_size, m_ien, 1'b0, m_halt, m_cont, 1'b0};
            4'd1: return {27'd0, m_pct, m_err, m_opd, m_blk, (m_st != 0)};
            4'd2: return m_code;
            4'd3: return m_addr;
            4'd4: return {16'd0, m_cnt};
            4'd5: return {29'd0, m_fc};
            4'd6: return m_baddr;
            4'd7: return {16'd0, m_bcnt};
            4'd8: return {29'd0, m_bfc};
            default: return 32'd0;
        endcase
    endfunction

    task automatic model_step();
        int o_st; logic o_halt, o_cont, o_pend; logic [15:0] o_cnt, o_bcnt;
        logic [31:0] o_baddr; logic [2:0] o_bfc; logic [1:0] o_size;
        bit idle, cw, sw, fin, rel, take; int code;
        if (!rst_n) begin
            m_st = 0; m_addr = 0; m_baddr = 0; m_cnt = 0; m_bcnt = 0; m_fc = 0; m_bfc = 0;
            m_cont = 0; m_halt = 0; m_ien = 0; m_pend = 0; m_size = 0;
            m_blk = 0; m_opd = 0; m_err = 0; m_pct = 0; m_code = 0;
            return;
        end
        o_st = m_st; o_halt = m_halt; o_cont = m_cont; o_pend = m_pend; o_cnt = m_cnt;
        o_bcnt = m_bcnt; o_baddr = m_baddr; o_bfc = m_bfc; o_size = m_size;
        idle = (o_st == 0);
        cw = wr_en && wr_sel == 4'd0;
        sw = wr_en && wr_sel == 4'd1;
        fin = 0; rel = 0; take = 0; code = 0;
        if (wr_en && idle) begin
            if (wr_sel == 4'd3) m_addr = wr_data;
            if (wr_sel == 4'd4) m_cnt = wr_data[15:0];
            if (wr_sel == 4'd5) m_fc = wr_data[2:0];
        end
        if (wr_en && wr_sel == 4'd6) m_baddr = wr_data;
        if (wr_en && wr_sel == 4'd7) m_bcnt = wr_data[15:0];
        if (wr_en && wr_sel == 4'd8) m_bfc = wr_data[2:0];
        if (cw) begin
            m_cont = wr_data[1]; m_halt = wr_data[2]; m_ien = wr_data[4]; m_size = wr_data[6:5];
        end
        if (cw && wr_data[3] && !idle) begin
            fin = 1; code = 3;
        end else if (cw && wr_data[0] && !wr_data[2] && !wr_data[3] && idle) begin
            if (o_cnt == 0) begin fin = 1; code = 2; end
            else begin m_st = 1; m_code = 0; end
        end else if (o_st == 1) begin
            if (o_halt) m_st = 2;
            else if (o_pend) begin take = 1; m_st = 3; end
        end else if (o_st == 2) begin
            if (!o_halt) m_st = 1;
        end else if (o_st == 3) begin
            if (bus_err) begin fin = 1; code = 1; end
            else if (bus_ack) begin
                m_addr = m_addr + nbytes(o_size);
                m_cnt = o_cnt - 16'd1;
                if (o_cnt != 16'd1) m_st = 1;
                else if (!o_cont) fin = 1;
                else if (o_bcnt == 0) begin fin = 1; code = 2; end
                else begin
                    m_addr = o_baddr; m_cnt = o_bcnt; m_fc = o_bfc;
                    m_cont = 0; rel = 1; m_st = 1;
                end
            end
        end
        if (sw) begin
            if (wr_data[1]) m_blk = 0;
            if (wr_data[2]) m_opd = 0;
            if (wr_data[3]) m_err = 0;
            if (wr_data[4]) m_pct = 0;
        end
        if (rel) m_blk = 1;
        if (fin) begin
            m_st = 0; m_opd = 1; m_code = code;
            if (code != 0) m_err = 1;
        end
        if (periph_fall) m_pct = 1;
        m_pend = idle ? 1'b0 : (xfer_req | (o_pend & !take));
    endtask

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        model_step();
        #2;
        if (rst_n && !done) begin
            chk({31'd0, bus_req}, {31'd0, m_st == 3}, "R3 bus_req vs model");
            chk(bus_addr, m_addr, "R3 bus_addr vs model");
            chk({29'd0, bus_fc}, {29'd0, m_fc}, "R5 bus_fc vs model");
            chk({30'd0, bus_size}, {30'd0, m_size}, "R3 bus_size vs model");
            chk({31'd0, irq}, {31'd0, m_ien & (m_blk | m_opd | m_pct)}, "R10 irq vs model");
            chk(rd_data, m_read(rd_sel), "R11 rd_data vs model");
        end
    end

    task automatic summary();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000 && !done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            summary();
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input logic [3:0] s, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd_chk(input logic [3:0] s, input logic [31:0] exp, input string tag);
        @(negedge clk); rd_sel = s; #1;
        chk(rd_data, exp, tag);
    endtask

    task automatic pulse_req();
        @(negedge clk); xfer_req = 1'b1;
        @(negedge clk); xfer_req = 1'b0;
    endtask

    task automatic wait_bus();
        int k = 0;
        while (!bus_req && k < 40) begin @(negedge clk); k++; end
        chk({31'd0, bus_req}, 32'd1, "R3 bus_req raised for latched request");
    endtask

    task automatic serve(input bit with_err);
        pulse_req();
        wait_bus();
        bus_ack = !with_err; bus_err = with_err;
        @(negedge clk); bus_ack = 1'b0; bus_err = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic clear_stat();
        wr(4'd1, 32'h1E);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd_chk(4'd1, 32'h0, "R1 status after reset");
        rd_chk(4'd3, 32'h0, "R1 address after reset");
        chk({31'd0, bus_req}, 32'd0, "R1 bus_req after reset");
        chk({31'd0, irq}, 32'd0, "R1 irq after reset");

        // R2 R3 R4: three 4-byte operands, no continuation
        wr(4'd3, 32'h1000); wr(4'd4, 32'd3); wr(4'd5, 32'd5);
        wr(4'd0, 32'h51);
        rd_chk(4'd1, 32'h01, "R2 active after start");
        rd_chk(4'd0, 32'h50, "R2 go reads back as 0");
        repeat (3) serve(1'b0);
        rd_chk(4'd3, 32'h100C, "R3 address after three 4-byte steps");
        rd_chk(4'd4, 32'h0, "R4 count exhausted");
        rd_chk(4'd1, 32'h04, "R4 complete without error");
        rd_chk(4'd2, 32'h0, "R4 error code none");
        chk({31'd0, irq}, 32'd1, "R10 irq on completion");
        wr(4'd1, 32'h04);
        rd_chk(4'd1, 32'h0, "R11 complete cleared by write-1");
        chk({31'd0, irq}, 32'd0, "R10 irq low after clear");

        // R5 R12: continuation with 2-byte operands
        wr(4'd3, 32'h40); wr(4'd4, 32'd2); wr(4'd5, 32'd2);
        wr(4'd6, 32'h2000); wr(4'd7, 32'd2); wr(4'd8, 32'd6);
        wr(4'd0, 32'h23);
        repeat (2) serve(1'b0);
        rd_chk(4'd3, 32'h2000, "R5 address reloaded from base");
        rd_chk(4'd4, 32'd2, "R5 count reloaded from base");
        rd_chk(4'd5, 32'd6, "R5 function code reloaded from base");
        rd_chk(4'd1, 32'h03, "R5 block done and still active");
        rd_chk(4'd0, 32'h20, "R5 continue cleared");
        wr(4'd3, 32'h9999);
        rd_chk(4'd3, 32'h2000, "R12 working address write ignored while active");
        wr(4'd6, 32'h3000);
        rd_chk(4'd6, 32'h3000, "R12 base address writable while active");
        repeat (2) serve(1'b0);
        rd_chk(4'd3, 32'h2004, "R3 2-byte steps in second block");
        rd_chk(4'd1, 32'h06, "R4 second block ends the channel");
        clear_stat();

        // R6: abort in the middle of a bus cycle
        wr(4'd3, 32'h100); wr(4'd4, 32'd5); wr(4'd0, 32'h01);
        serve(1'b0);
        rd_chk(4'd3, 32'h101, "R3 1-byte step");
        pulse_req();
        wait_bus();
        wr(4'd0, 32'h08);
        chk({31'd0, bus_req}, 32'd0, "R6 bus_req dropped by abort");
        rd_chk(4'd1, 32'h0C, "R6 complete and error after abort");
        rd_chk(4'd2, 32'd3, "R6 abort error code");
        rd_chk(4'd0, 32'h0, "R6 abort bit reads 0");
        clear_stat();
        wr(4'd0, 32'h08);
        rd_chk(4'd1, 32'h0, "R6 abort while idle ignored");

        // R7: bus exception
        wr(4'd3, 32'h500); wr(4'd4, 32'd4); wr(4'd0, 32'h41);
        serve(1'b1);
        rd_chk(4'd1, 32'h0C, "R7 complete and error after exception");
        rd_chk(4'd2, 32'd1, "R7 bus error code");
        rd_chk(4'd3, 32'h500, "R7 address not stepped");
        rd_chk(4'd4, 32'd4, "R7 count not stepped");
        clear_stat();

        // R2 R8: halt
        wr(4'd3, 32'h0); wr(4'd4, 32'd2);
        wr(4'd0, 32'h05);
        rd_chk(4'd1, 32'h0, "R2 go with halt does not start");
        wr(4'd0, 32'h01);
        wr(4'd0, 32'h04);
        pulse_req();
        repeat (6) @(negedge clk);
        chk({31'd0, bus_req}, 32'd0, "R8 no bus cycle while halted");
        rd_chk(4'd1, 32'h01, "R8 still active while halted");
        wr(4'd0, 32'h00);
        wait_bus();
        bus_ack = 1'b1; @(negedge clk); bus_ack = 1'b0;
        rd_chk(4'd3, 32'h1, "R8 latched request serviced after halt");
        serve(1'b0);
        rd_chk(4'd1, 32'h04, "R8 channel completes after resume");
        clear_stat();

        // R9: zero counts
        wr(4'd4, 32'd0); wr(4'd0, 32'h01);
        rd_chk(4'd1, 32'h0C, "R9 start with zero count");
        rd_chk(4'd2, 32'd2, "R9 config error code");
        clear_stat();
        wr(4'd7, 32'd0); wr(4'd4, 32'd1); wr(4'd0, 32'h03);
        serve(1'b0);
        rd_chk(4'd1, 32'h0C, "R9 continuation with zero base count");
        rd_chk(4'd2, 32'd2, "R9 config error code on reload");
        rd_chk(4'd4, 32'd0, "R9 count left at zero");
        clear_stat();

        // R10 R11: peripheral transition, clear racing a set
        wr(4'd0, 32'h10);
        @(negedge clk); periph_fall = 1'b1; @(negedge clk); periph_fall = 1'b0;
        chk({31'd0, irq}, 32'd1, "R10 irq from peripheral transition");
        rd_chk(4'd1, 32'h10, "R10 transition bit set");
        @(negedge clk); wr_en = 1'b1; wr_sel = 4'd1; wr_data = 32'h10; periph_fall = 1'b1;
        @(negedge clk); wr_en = 1'b0; periph_fall = 1'b0;
        rd_chk(4'd1, 32'h10, "R11 set wins over same-cycle clear");
        wr(4'd0, 32'h00);
        chk({31'd0, irq}, 32'd0, "R10 irq masked when enable clear");
        clear_stat();
        rd_chk(4'd1, 32'h0, "R11 transition bit cleared");

        // R3: size code 3 steps by 4
        wr(4'd3, 32'h10); wr(4'd4, 32'd1); wr(4'd0, 32'h61);
        serve(1'b0);
        rd_chk(4'd3, 32'h14, "R3 size code 3 steps by 4");
        clear_stat();

        // R13: idle requests dropped
        wr(4'd4, 32'd1);
        pulse_req();
        wr(4'd0, 32'h01);
        repeat (4) @(negedge clk);
        chk({31'd0, bus_req}, 32'd0, "R13 idle request not kept");
        serve(1'b0);
        rd_chk(4'd1, 32'h04, "R13 later request completes block");

        repeat (3) @(negedge clk);
        summary();
    end

endmodule